// File: doc/BRIEF.md
# Serial 1001 Pattern Recognizer (Moore and Mealy pair)

The block reads one bit per rising clock edge from a serial input and reports every occurrence of the bit pattern 1001. Overlapping occurrences count. The final 1 of one match can also be the first 1 of the next match, so the stream 1001001 produces two detections.

Two independent machines read the same input and drive two flags side by side. The state-driven flag comes from a five-state machine and is held in a register, so it changes only on a clock edge. It rises in the cycle after the completing bit has been clocked in. The input-driven flag comes from a four-state machine. It is combinational in the present state and the present input bit, so it rises while the completing 1 is still on the input, one clock earlier than the state-driven flag. Both state registers are brought out as ports so their binary state numbers can be observed.

Top module: `seq1001_detect`

## Requirements
- R1: The five-state machine holds a 3-bit state number that starts at 0. Its transitions, written as (state, input -> next), are: 0,0->0; 0,1->1; 1,0->2; 1,1->1; 2,0->3; 2,1->1; 3,0->0; 3,1->4; 4,0->2; 4,1->1. The state appears on `moore_state`.
- R2: `moore_hit` is high exactly in the cycles when `moore_state` is 4. It is registered, so it changes only at a rising clock edge.
- R3: The four-state machine holds a 2-bit state number that starts at 0. Its transitions are: 0,0->0; 0,1->1; 1,0->2; 1,1->1; 2,0->3; 2,1->1; 3,0->0; 3,1->1. The state appears on `mealy_state`.
- R4: `mealy_hit` is high exactly when `mealy_state` is 3 and `din` is 1. It follows changes of `din` between clock edges.
- R5: Overlapping matches are all reported. The stream 1001001 gives two pulses on each flag.
- R6: While `rst` is high, `mealy_hit` is low. A rising edge with `rst` high sets both state numbers to 0 and clears `moore_hit`.
- R7: If the five-state register holds an unused code (5, 6 or 7), the next rising edge without reset moves it to state 0, and `moore_hit` is low after that edge.
- R8: For every input stream, `moore_hit` is high in a cycle exactly when `mealy_hit` was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit is taken per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, stable around the rising edge |
| moore_hit | output | 1 | Registered detection flag from the five-state machine |
| mealy_hit | output | 1 | Combinational detection flag from the four-state machine |
| moore_state | output | 3 | Current state number of the five-state machine |
| mealy_state | output | 2 | Current state number of the four-state machine |

## Verification
The bench checks the overlap case that is most likely to go wrong. A design that returns to state 0 after a match misses the second detection in 1001001. A design that sends state 4 on a 0 back to 0 instead of 2 misses 1001 that follows a bare 10. The bench toggles the input between edges while the four-state machine waits in state 3. A registered input-driven flag would not follow those toggles, and a flag that ignores the input would stay high. The bench forces an unused code into the five-state register to confirm that the machine recovers to state 0 and does not lock up. It applies reset while a detection is pending and also while the input-driven flag would otherwise be high, to confirm that both flags stay low.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int MO_W = 3;
  localparam int ME_W = 2;

  // state numbers of the five-state machine
  localparam logic [MO_W-1:0] MO_IDLE = 3'd0;
  localparam logic [MO_W-1:0] MO_G1   = 3'd1;
  localparam logic [MO_W-1:0] MO_G10  = 3'd2;
  localparam logic [MO_W-1:0] MO_G100 = 3'd3;
  localparam logic [MO_W-1:0] MO_HIT  = 3'd4;
  localparam logic [MO_W-1:0] MO_LAST = MO_HIT;

  // state numbers of the four-state machine
  localparam logic [ME_W-1:0] ME_IDLE = 2'd0;
  localparam logic [ME_W-1:0] ME_G1   = 2'd1;
  localparam logic [ME_W-1:0] ME_G10  = 2'd2;
  localparam logic [ME_W-1:0] ME_G100 = 2'd3;
endpackage

// File: rtl/seqdet_moore.sv
module seqdet_moore
  import seqdet_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  output logic            hit,
  output logic [MO_W-1:0] state
);
  logic [MO_W-1:0] state_q;
  logic [MO_W-1:0] state_d;
  logic            hit_q;

  always_comb begin
    case (state_q)
      MO_IDLE: state_d = din ? MO_G1   : MO_IDLE;
      MO_G1:   state_d = din ? MO_G1   : MO_G10;
      MO_G10:  state_d = din ? MO_G1   : MO_G100;
      MO_G100: state_d = din ? MO_HIT  : MO_IDLE;
      MO_HIT:  state_d = din ? MO_G1   : MO_G10;
      default: state_d = MO_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MO_IDLE;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hit_q   <= (state_d == MO_HIT);
    end
  end

  assign hit   = hit_q;
  assign state = state_q;

  assert_bad_code_recovers_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q > MO_LAST) |=> (state_q == MO_IDLE && !hit_q));

  assert_hit_only_in_top_state_R2: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> (state_q == MO_HIT));

  assert_hit_after_one_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_q) |-> $past(din));

  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> (state_q == MO_IDLE && !hit_q));
endmodule

// File: rtl/seqdet_mealy.sv
module seqdet_mealy
  import seqdet_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  output logic            hit,
  output logic [ME_W-1:0] state
);
  logic [ME_W-1:0] state_q;
  logic [ME_W-1:0] state_d;

  always_comb begin
    case (state_q)
      ME_IDLE: state_d = din ? ME_G1 : ME_IDLE;
      ME_G1:   state_d = din ? ME_G1 : ME_G10;
      ME_G10:  state_d = din ? ME_G1 : ME_G100;
      default: state_d = din ? ME_G1 : ME_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ME_IDLE;
    else     state_q <= state_d;
  end

  assign hit   = !rst && (state_q == ME_G100) && din;
  assign state = state_q;

  assert_two_zeros_reach_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ME_G10 && !din) |=> (state_q == ME_G100));

  assert_hit_leaves_to_one_R5: assert property (@(posedge clk) disable iff (rst)
    hit |=> (state_q == ME_G1));
endmodule

// File: rtl/seq1001_detect.sv
module seq1001_detect
  import seqdet_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  output logic            moore_hit,
  output logic            mealy_hit,
  output logic [MO_W-1:0] moore_state,
  output logic [ME_W-1:0] mealy_state
);
  seqdet_moore u_moore (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .hit   (moore_hit),
    .state (moore_state)
  );

  seqdet_mealy u_mealy (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .hit   (mealy_hit),
    .state (mealy_state)
  );

  assert_mealy_leads_moore_R8: assert property (@(posedge clk) disable iff (rst)
    mealy_hit |=> moore_hit);

  assert_moore_follows_mealy_R8: assert property (@(posedge clk) disable iff (rst)
    moore_hit |-> $past(mealy_hit));
endmodule

// File: tb/sim_seq1001_detect.sv
`timescale 1ns/100ps
module sim_seq1001_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic       moore_hit, mealy_hit;
  logic [2:0] moore_state;
  logic [1:0] mealy_state;

  int n_chk  = 0;
  int n_fail = 0;
  int mealy_pulses = 0;

  always #2.5 clk = ~clk;

  seq1001_detect u0 (
    .clk(clk), .rst(rst), .din(din),
    .moore_hit(moore_hit), .mealy_hit(mealy_hit),
    .moore_state(moore_state), .mealy_state(mealy_state)
  );

  localparam int NVEC = 7;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h9249, 16'h9999, 16'h0F09, 16'hA590, 16'hC924, 16'hFFFF, 16'h0000
  };

  // reference model built from the transition lists in R1 and R3
  logic [3:0] hist;
  logic [2:0] m_mo;
  logic [1:0] m_me;
  logic       pend;
  logic       pend_hit;

  function automatic logic [2:0] mo_next(logic [2:0] s, logic b);
    case (s)
      3'd0: return b ? 3'd1 : 3'd0;
      3'd1: return b ? 3'd1 : 3'd2;
      3'd2: return b ? 3'd1 : 3'd3;
      3'd3: return b ? 3'd4 : 3'd0;
      3'd4: return b ? 3'd1 : 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] me_next(logic [1:0] s, logic b);
    case (s)
      2'd0: return b ? 2'd1 : 2'd0;
      2'd1: return b ? 2'd1 : 2'd2;
      2'd2: return b ? 2'd1 : 2'd3;
      default: return b ? 2'd1 : 2'd0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    hist = 4'b0000; m_mo = 3'd0; m_me = 2'd0; pend = 1'b0; pend_hit = 1'b0;
  endtask

  // called just after a falling edge: compares the results of the last rising edge
  task automatic check_pending();
    if (pend) begin
      chk("R1 moore_state", moore_state, m_mo);
      chk("R3 mealy_state", mealy_state, m_me);
      chk("R2 moore_hit", moore_hit, pend_hit);
      chk("R8 moore_hit one cycle after mealy_hit", moore_hit, pend_hit);
    end
  endtask

  task automatic send(input logic b, input logic wiggle);
    logic match;
    @(negedge clk);
    #0.2;
    check_pending();
    match = ({hist[2:0], b} == 4'b1001);
    if (wiggle) begin
      din = 1'b0; #0.3;
      chk("R4 mealy_hit low with din 0", mealy_hit, 0);
      din = 1'b1; #0.3;
      chk("R4 mealy_hit follows din between edges", mealy_hit, (m_me == 2'd3) ? 1 : 0);
      din = 1'b0; #0.3;
      chk("R4 mealy_hit drops with din", mealy_hit, 0);
    end
    din = b;
    #0.3;
    chk("R4 mealy_hit same cycle", mealy_hit, match);
    if (mealy_hit) mealy_pulses++;
    hist = {hist[2:0], b};
    m_mo = mo_next(m_mo, b);
    m_me = me_next(m_me, b);
    pend = 1'b1;
    pend_hit = match;
  endtask

  task automatic flush();
    @(negedge clk);
    #0.2;
    check_pending();
    pend = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    @(negedge clk);
    #0.2;
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    #0.2;
    // R6 reset state
    chk("R6 moore_state after reset", moore_state, 0);
    chk("R6 mealy_state after reset", mealy_state, 0);
    chk("R6 moore_hit after reset", moore_hit, 0);
    chk("R6 mealy_hit in reset", mealy_hit, 0);
    rst = 1'b0;

    // vector table walk, MSB first, state kept across words
    for (int v = 0; v < NVEC; v++)
      for (int i = 15; i >= 0; i--)
        send(VEC[v][i], 1'b0);
    flush();

    // R5 overlap: 1001001 gives two pulses
    do_reset();
    mealy_pulses = 0;
    send(1,0); send(0,0); send(0,0); send(1,0); send(0,0); send(0,0); send(1,0);
    flush();
    chk("R5 overlap pulse count", mealy_pulses, 2);

    // R4 toggling din between edges while waiting in state 3
    do_reset();
    send(1,0); send(0,0); send(0,0); send(0,1); send(1,0); send(0,0); send(0,0); send(1,1);
    flush();

    // R6 reset with pending detection and with mealy_hit otherwise high
    do_reset();
    send(1,0); send(0,0); send(0,0); send(1,0);
    @(negedge clk);
    #0.2;
    check_pending();
    chk("R2 moore_hit up before reset", moore_hit, 1);
    rst = 1'b1;
    @(negedge clk);
    #0.2;
    chk("R6 moore_hit cleared", moore_hit, 0);
    chk("R6 moore_state cleared", moore_state, 0);
    rst = 1'b0;
    model_reset();
    send(1,0); send(0,0); send(0,0);
    @(negedge clk);
    #0.2;
    check_pending();
    rst = 1'b1;
    din = 1'b1;
    #0.3;
    chk("R6 mealy_hit held low in reset", mealy_hit, 0);
    @(negedge clk);
    #0.2;
    chk("R6 mealy_state cleared", mealy_state, 0);
    chk("R6 moore_state cleared after wait", moore_state, 0);
    rst = 1'b0;
    din = 1'b0;
    model_reset();

    // R7 recovery from an unused code
    send(0,0);
    @(negedge clk);
    #0.2;
    check_pending();
    pend = 1'b0;
    force u0.u_moore.state_q = 3'd5;
    #0.1;
    release u0.u_moore.state_q;
    #0.1;
    chk("R7 unused code visible", moore_state, 5);
    @(negedge clk);
    #0.2;
    chk("R7 recovered to state 0", moore_state, 0);
    chk("R7 moore_hit low after recovery", moore_hit, 0);
    m_mo = 3'd0;
    send(1,0); send(0,0); send(0,0); send(1,0);
    flush();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule